// File: doc/BRIEF.md
# Ring-Buffer Command Queue Fetcher

This block is the front end that feeds a graphics accelerator from a circular command buffer in memory. Software describes the buffer by its 128-byte aligned base address and its inclusive last byte address. It describes one batch by a byte offset into that buffer and a byte length. A single write to the launch register then resets the fetch state, enables the queue and starts the batch. The block issues word-sized read requests one after another. When an address would pass the last byte of the buffer, the next address goes back to the base, so a batch may wrap partway through.

Read data comes back in request order on a valid/ready request port and a valid-only response port. Each returned word is forwarded unchanged to a downstream command consumer. The block reports the end of a batch, or a fault, through two status flags. Each flag has its own interrupt enable, and a busy flag shows when a batch is in flight. Up to `MAX_OUT` reads may be outstanding at once.

The register map uses word indices on `reg_addr`:
- 0 is the interrupt enables: bit0 for done, bit1 for fault.
- 1 is status: bit0 done, bit1 fault, bit2 busy, read-only.
- 2 is launch: bit0 go, bit1 queue enable, bit2 soft reset.
- 3 is the buffer base.
- 4 is the buffer last byte.
- 5 is the batch offset.
- 6 is the batch length in bytes.

Top module: `cmdq_fetcher`

## Requirements
- R1: After reset every register reads zero, and `irq`, `req_valid` and `cmd_valid` are low.
- R2: Buffer base bits [6:0] always read as zero. The last-byte, offset and length registers read back exactly what was written.
- R3: A batch starts only when a launch write sets both go (bit0) and queue enable (bit1). Its first request address is base plus offset. A launch write without both bits issues no request.
- R4: Each accepted request advances the address by one bus word (4 bytes). If that step would exceed the last-byte address, the next address is the base instead.
- R5: A batch of L bytes issues exactly ceil(L/4) requests.
- R6: Response words of a running batch appear on `cmd_data` in request order, one per response, and `cmd_valid` is never high while the block is not busy.
- R7: The done flag (status bit0) is set once the last response of the batch has returned, and busy (bit2) then falls.
- R8: A response with `rsp_err` high sets the fault flag (status bit1), stops further requests, and that word and all later ones are not forwarded.
- R9: A launch with a zero length sets the fault flag and issues no request.
- R10: `irq` is high exactly when some status flag is set together with its enable bit. Writing zero to the enable register forces `irq` low.
- R11: Writing a one to status bit0 or bit1 clears that flag. Writing a zero leaves it unchanged.
- R12: Launch writes made while busy are ignored. No second batch starts.
- R13: A launch write with the soft-reset bit (bit2) clears only the fetch counters. Base, last-byte, offset and length keep their values, and when the same write also carries go and enable, the batch still starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data, combinational on `reg_addr` |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | AW | Read request byte address |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | DW | Read response word |
| rsp_err | input | 1 | Read response fault |
| cmd_valid | output | 1 | Command word valid to consumer |
| cmd_data | output | DW | Command word to consumer |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume several things about the environment:
- Responses return in request order, and none arrives without an outstanding request.
- The base, last-byte and offset registers describe a window that holds the start address.
- Software leaves those registers alone while a batch is busy.

The stimulus respects all of this. A memory model answers only from its own queue of accepted addresses. Every batch fits its offset inside the programmed buffer, and reprogramming happens only after status polling shows busy low. Request backpressure and response gaps follow a fixed cycle pattern, and the model can stall its ready line outright, so both wrapping and the busy window are reached.

// File: rtl/cmdq_fetcher.sv
module cmdq_fetcher #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int MAX_OUT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          rsp_err,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_data,
  output logic          irq
);
  localparam int WB  = DW / 8;
  localparam int WSH = $clog2(WB);
  localparam int OW  = $clog2(MAX_OUT + 1);

  logic [1:0]    ctrl_en;
  logic          st_fin, st_err, active;
  logic [AW-1:0] base_q, last_q, ofs_q, len_q;
  logic [AW-1:0] fetch_addr, req_left, rsp_left;
  logic [OW-1:0] outst;

  wire busy     = active || (outst != '0);
  wire wr_ctrl  = reg_we && reg_addr == 3'd0;
  wire wr_stat  = reg_we && reg_addr == 3'd1;
  wire wr_start = reg_we && reg_addr == 3'd2 && !busy;
  wire go_ok    = wr_start && reg_wdata[0] && reg_wdata[1];
  wire srst     = wr_start && reg_wdata[2];
  wire [AW-1:0] words = (len_q + AW'(WB - 1)) >> WSH;

  assign req_valid = active && (req_left != '0) && (outst < OW'(MAX_OUT));
  assign req_addr  = fetch_addr;
  wire fire   = req_valid && req_ready;
  wire rsp_ok = rsp_valid && active && !rsp_err;
  wire rsp_bad = rsp_valid && active && rsp_err;
  wire dec    = rsp_valid && (outst != '0);
  wire [AW:0] step = {1'b0, fetch_addr} + (AW+1)'(WB);
  wire [AW-1:0] next_addr = (step > {1'b0, last_q}) ? base_q : step[AW-1:0];

  assign cmd_valid = rsp_ok;
  assign cmd_data  = rsp_data;
  assign irq       = |({st_err, st_fin} & ctrl_en);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {{(AW-2){1'b0}}, ctrl_en};
      3'd1:    reg_rdata = {{(AW-3){1'b0}}, busy, st_err, st_fin};
      3'd3:    reg_rdata = base_q;
      3'd4:    reg_rdata = last_q;
      3'd5:    reg_rdata = ofs_q;
      3'd6:    reg_rdata = len_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en    <= '0;
      st_fin     <= 1'b0;
      st_err     <= 1'b0;
      active     <= 1'b0;
      base_q     <= '0;
      last_q     <= '0;
      ofs_q      <= '0;
      len_q      <= '0;
      fetch_addr <= '0;
      req_left   <= '0;
      rsp_left   <= '0;
      outst      <= '0;
    end else begin
      if (wr_ctrl) ctrl_en <= reg_wdata[1:0];
      if (reg_we && reg_addr == 3'd3) base_q <= {reg_wdata[AW-1:7], 7'b0};
      if (reg_we && reg_addr == 3'd4) last_q <= reg_wdata;
      if (reg_we && reg_addr == 3'd5) ofs_q  <= reg_wdata;
      if (reg_we && reg_addr == 3'd6) len_q  <= reg_wdata;
      if (wr_stat) begin
        if (reg_wdata[0]) st_fin <= 1'b0;
        if (reg_wdata[1]) st_err <= 1'b0;
      end
      outst <= outst + OW'(fire) - OW'(dec);
      if (srst) begin
        req_left <= '0;
        rsp_left <= '0;
        active   <= 1'b0;
      end
      if (go_ok) begin
        if (len_q == '0) begin
          st_err <= 1'b1;
        end else begin
          active     <= 1'b1;
          fetch_addr <= base_q + ofs_q;
          req_left   <= words;
          rsp_left   <= words;
        end
      end else if (active) begin
        if (fire) begin
          fetch_addr <= next_addr;
          req_left   <= req_left - 1'b1;
        end
        if (rsp_bad) begin
          active   <= 1'b0;
          req_left <= '0;
          st_err   <= 1'b1;
        end else if (rsp_ok) begin
          rsp_left <= rsp_left - 1'b1;
          if (rsp_left == AW'(1)) begin
            active <= 1'b0;
            st_fin <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cmdq_fetcher_chk.sv
module cmdq_fetcher_chk #(
  parameter int AW = 32,
  parameter int WB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          cmd_valid,
  input logic          irq,
  input logic          busy,
  input logic          active,
  input logic          st_fin,
  input logic          st_err,
  input logic [1:0]    ctrl_en,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] last_q
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !(rsp_valid && rsp_err) |=> req_valid && $stable(req_addr)); // R4
  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ({1'b0, req_addr} + (AW+1)'(WB) > {1'b0, last_q}) |=> req_addr == base_q); // R4
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R3
  AST_CMD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy); // R6
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_err) |-> !req_valid); // R8
  AST_FIN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_fin) |-> !active); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en == 2'b00 |-> !irq); // R10
endmodule

bind cmdq_fetcher cmdq_fetcher_chk #(.AW(AW), .WB(DW/8)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .cmd_valid(cmd_valid), .irq(irq), .busy(busy), .active(active),
  .st_fin(st_fin), .st_err(st_err), .ctrl_en(ctrl_en),
  .base_q(base_q), .last_q(last_q)
);

// File: tb/cmdq_fetcher_tb_top.sv
module cmdq_fetcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] LAST = 32'h0000_10FF;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic req_valid, req_ready = 0;
  logic [31:0] req_addr;
  logic rsp_valid = 0, rsp_err = 0;
  logic [31:0] rsp_data = 0;
  logic cmd_valid;
  logic [31:0] cmd_data;
  logic irq;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, req_count = 0, rsp_count = 0, err_at = -1;
  bit hold_ready = 0;
  logic [31:0] pend_q[$];
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdq_fetcher dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model
  always @(negedge clk)
    if (rst_n && req_valid && req_ready) begin
      pend_q.push_back(req_addr);
      req_count++;
    end

  always @(posedge clk) begin
    #1;
    cyc++;
    req_ready = !hold_ready && (cyc % 3 != 1);
    if (pend_q.size() > 0 && cyc % 2 == 0) begin
      logic [31:0] a;
      a = pend_q.pop_front();
      rsp_valid = 1;
      rsp_data  = a ^ 32'hA5A5_0000;
      rsp_err   = (rsp_count == err_at);
      rsp_count++;
    end else begin
      rsp_valid = 0;
      rsp_err   = 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk)
    if (rst_n && cmd_valid) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected word", cmd_data, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(cmd_data == e, "R6/R4 word order", cmd_data, e);
      end
    end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, s);
      if (!s[2]) return;
    end
    chk(0, "R7 busy never cleared", s, 32'h0);
  endtask

  task automatic drive_batch(input logic [31:0] ofs, input logic [31:0] len, input int n_exp);
    logic [31:0] a;
    a = BASE + ofs;
    for (int i = 0; i < n_exp; i++) begin
      exp_q.push_back(a ^ 32'hA5A5_0000);
      a = (a + 4 > LAST) ? BASE : a + 4;
    end
    wr(3'd5, ofs);
    wr(3'd6, len);
    wr(3'd2, 32'h3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int rc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(req_valid == 0, "R1 req_valid", req_valid, 0);
    chk(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
    rd(3'd1, v); chk(v == 0, "R1 status", v, 0);
    rd(3'd3, v); chk(v == 0, "R1 base", v, 0);

    wr(3'd3, 32'h0000_1234);
    rd(3'd3, v); chk(v == 32'h1200, "R2 base align", v, 32'h1200);
    wr(3'd3, BASE);
    wr(3'd4, LAST);
    rd(3'd4, v); chk(v == LAST, "R2 last readback", v, LAST);

    // plain batch, 40 bytes -> 10 words
    rc = req_count;
    drive_batch(32'h20, 40, 10);
    wait_idle();
    chk(req_count - rc == 10, "R5 request count", req_count - rc, 10);
    rd(3'd1, v); chk(v == 32'h1, "R7 done flag", v, 1);
    chk(irq == 0, "R10 masked irq", irq, 0);
    wr(3'd0, 32'h1);
    @(negedge clk); chk(irq == 1, "R10 irq on done", irq, 1);
    wr(3'd0, 32'h0);
    @(negedge clk); chk(irq == 0, "R10 irq disabled", irq, 0);
    wr(3'd1, 32'h1);
    rd(3'd1, v); chk(v == 0, "R11 clear done", v, 0);

    // wrapping batch, 37 bytes -> 10 words
    rc = req_count;
    drive_batch(32'hF0, 37, 10);
    wait_idle();
    chk(req_count - rc == 10, "R4 R5 wrap count", req_count - rc, 10);
    wr(3'd1, 32'h3);

    // go without enable
    rc = req_count;
    wr(3'd2, 32'h1);
    repeat (5) @(negedge clk);
    rd(3'd1, v);
    chk(v == 0 && req_count == rc, "R3 go without enable", v, 0);

    // zero length
    wr(3'd6, 0);
    wr(3'd2, 32'h3);
    repeat (4) @(negedge clk);
    rd(3'd1, v); chk(v == 32'h2, "R9 zero length fault", v, 2);
    chk(req_count == rc, "R9 no request", req_count - rc, 0);
    wr(3'd0, 32'h2);
    @(negedge clk); chk(irq == 1, "R10 irq on fault", irq, 1);
    wr(3'd1, 32'h1);
    rd(3'd1, v); chk(v == 32'h2, "R11 zero write keeps", v, 2);
    wr(3'd1, 32'h2);
    rd(3'd1, v); chk(v == 0, "R11 clear fault", v, 0);
    wr(3'd0, 0);

    // response error on the fourth word of a 16-word batch
    rc = req_count;
    err_at = rsp_count + 3;
    drive_batch(32'h0, 64, 3);
    wait_idle();
    err_at = -1;
    rd(3'd1, v); chk(v == 32'h2, "R8 fault status", v, 2);
    chk(req_count - rc < 16, "R8 stopped early", req_count - rc, 16);
    wr(3'd1, 32'h3);

    // launch while busy is ignored
    hold_ready = 1;
    rc = req_count;
    drive_batch(32'h40, 8, 2);
    rd(3'd1, v); chk(v[2] == 1, "R12 busy while stalled", v, 4);
    wr(3'd6, 32'h40);
    wr(3'd2, 32'h7);
    hold_ready = 0;
    wait_idle();
    chk(req_count - rc == 2, "R12 second launch ignored", req_count - rc, 2);
    wr(3'd1, 32'h3);

    // soft reset combined with go
    rc = req_count;
    exp_q.push_back((BASE + 32'h80) ^ 32'hA5A5_0000);
    wr(3'd5, 32'h80);
    wr(3'd6, 4);
    wr(3'd2, 32'h7);
    wait_idle();
    chk(req_count - rc == 1, "R13 start with soft reset", req_count - rc, 1);
    wr(3'd2, 32'h4);
    rd(3'd3, v); chk(v == BASE, "R13 base kept", v, BASE);
    rd(3'd4, v); chk(v == LAST, "R13 last kept", v, LAST);
    rd(3'd5, v); chk(v == 32'h80, "R13 offset kept", v, 32'h80);
    rd(3'd6, v); chk(v == 4, "R13 length kept", v, 4);
    rd(3'd1, v); chk(v == 1, "R7 done after soft reset batch", v, 1);

    chk(exp_q.size() == 0, "R6 all words seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule